// File: doc/BRIEF.md
# UART Channel Interrupt Priority Controller

This block collects every interrupt event of a single serial channel, holds each one as a pending source until that source's own clearing action occurs, and reports the most urgent enabled source as a six-bit code in the low bits of an interrupt status byte. The top two bits of that byte show whether the FIFOs are enabled. A single request line is raised while any enabled source, or the wake-up flag, is pending.

The receive time-out timer is part of the block. It counts bit-clock ticks that arrive on an input. The limit is four character times plus twelve bits, and the character length in bits is also an input.

The surrounding channel logic drives the block. It supplies the receive and transmit FIFO events, the line-status and modem-status change pulses, the in-band flow and special character detections, the flow-control pin levels, and the register access strobes. The block does not hold the data path or the FIFOs.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, status bits [5:0] read 000001, and both `irq` and `wake_flag` are 0.
- R2: Status bits [7:6] read 11 while `fifo_en` is 1 and read 00 while it is 0.
- R3: Enable bits of `src_en`:
  - bit0 gates line status.
  - bit1 gates receive data ready and receive time-out.
  - bit2 gates transmit ready.
  - bit3 gates modem status.
  - bit4 gates the character sources.
  - bit5 gates the pin changes.

  The enabled pending source shown is the most urgent one. The order, most urgent first, with codes, is:
  - line status 000110
  - receive data ready 000100
  - receive time-out 001100
  - transmit ready 000010
  - modem status 000000
  - flow or special character 010000
  - flow pin change 100000
- R4: Any set bit of `line_err` makes line status pending, and `lsr_rd` clears it.
- R5: Receive data ready is shown while `rx_level` is nonzero and at least `rx_trig`, and is gone as soon as the level falls below the trigger.
- R6: Receive time-out is controlled by a counter.
  - The counter runs only while `rx_level` is nonzero, counting `bit_tick` pulses.
  - `rx_char` and `rhr_rd` restart it, and an empty FIFO holds it at zero.
  - On the tick that brings the count to 4*`char_bits`+12, the time-out becomes pending.
  - `rhr_rd` clears the pending time-out.
- R7: A `tx_trig_hit` or `tx_empty` pulse makes transmit ready pending. It is cleared by `thr_wr`, or by `isr_rd` only when that read returned code 000010.
- R8: Any set bit of `msr_delta` makes modem status pending, and `msr_rd` clears it.
- R9: `xon_det`/`xoff_det` pending is cleared by `isr_rd`. `spec_det` pending is cleared by `isr_rd` or by the next `rx_char`.
- R10: A low-to-high change of `flow_pin[i]` while `flow_auto[i]` is 1 makes pin change pending. Here i=0 is the input pin pair and i=1 the output pin pair. The change has no effect while `flow_auto[i]` is 0, and `msr_rd` clears the pending state.
- R11: `wake_evt` sets `wake_flag` independent of `src_en`, and `gir_rd` clears it.
- R12: `irq` is 1 exactly when an enabled source is pending or `wake_flag` is 1.
- R13: When a set event and a clearing action reach the same source in the same cycle, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFOs enabled flag |
| src_en | input | 6 | Per-source enables |
| line_err | input | 4 | Line error event pulses |
| lsr_rd | input | 1 | Line-status register read strobe |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| rx_char | input | 1 | A character was received |
| rhr_rd | input | 1 | Receive holding register read strobe |
| bit_tick | input | 1 | One pulse per bit time |
| char_bits | input | CHAR_W | Bits per character frame |
| tx_trig_hit | input | 1 | Transmit FIFO reached its trigger |
| tx_empty | input | 1 | Transmit FIFO became empty |
| thr_wr | input | 1 | Transmit holding register write strobe |
| isr_rd | input | 1 | Status register read strobe |
| msr_delta | input | 4 | Modem status change pulses |
| msr_rd | input | 1 | Modem-status register read strobe |
| xon_det | input | 1 | Resume character detected |
| xoff_det | input | 1 | Pause character detected |
| spec_det | input | 1 | Special character detected |
| flow_pin | input | 2 | Flow-control pin levels (0 input pair, 1 output pair) |
| flow_auto | input | 2 | Automatic flow control enabled per pin |
| wake_evt | input | 1 | Channel left sleep mode |
| gir_rd | input | 1 | Global interrupt register read strobe |
| isr_byte | output | 8 | Interrupt status byte |
| irq | output | 1 | Combined interrupt request |
| wake_flag | output | 1 | Wake-up indicator |

## Verification
Two of this block's functions can meet in the same cycle: the clearing action of a source and a fresh set event for that source. The bench provokes this in two ways. First, a status read that returns the transmit-ready code is issued in the same cycle as a new `tx_empty` pulse. Second, `rx_char` is pulsed together with `spec_det`. In both cases the bench expects the code to remain pending after the edge, and then clears it with a lone clearing action to show that the clear path itself works.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int NUM_LVL   = 7;
   localparam int NUM_LATCH = 9;

   // latch slots
   localparam int LT_LINE  = 0;
   localparam int LT_RXTO  = 1;
   localparam int LT_TX    = 2;
   localparam int LT_MODEM = 3;
   localparam int LT_FLOWC = 4;
   localparam int LT_SPEC  = 5;
   localparam int LT_PIN0  = 6;
   localparam int LT_PIN1  = 7;
   localparam int LT_WAKE  = 8;

   typedef enum logic [5:0] {
      IC_LINE  = 6'b000110,
      IC_RXRDY = 6'b000100,
      IC_RXTO  = 6'b001100,
      IC_TXRDY = 6'b000010,
      IC_MODEM = 6'b000000,
      IC_CHAR  = 6'b010000,
      IC_PIN   = 6'b100000,
      IC_NONE  = 6'b000001
   } irq_code_e;

   // priority level index (0 = most urgent) to status code
   function automatic irq_code_e lvl_code(input int idx);
      case (idx)
         0:       return IC_LINE;
         1:       return IC_RXRDY;
         2:       return IC_RXTO;
         3:       return IC_TXRDY;
         4:       return IC_MODEM;
         5:       return IC_CHAR;
         6:       return IC_PIN;
         default: return IC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pend <= 1'b0;
            else if (set) pend <= 1'b1;
            else if (clr) pend <= 1'b0;
         end

         assert_set_keeps_R13: assert property (@(posedge clk) disable iff (!rst_n)
            set |=> pend);
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pend <= 1'b0;
            else if (clr) pend <= 1'b0;
            else if (set) pend <= 1'b1;
         end

         assert_clr_first_R13: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> !pend);
      end
   endgenerate

endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
   parameter int LVL_W  = 7,
   parameter int CHAR_W = 4,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              rx_char,
   input  logic              rhr_rd,
   input  logic              bit_tick,
   input  logic [CHAR_W-1:0] char_bits,
   output logic              fire
);

   localparam int MAX_LIMIT = 4 * ((1 << CHAR_W) - 1) + 12;
   localparam int NEED_W    = $clog2(MAX_LIMIT + 1);

   initial begin
      assert_cnt_width_R6: assert (CNT_W >= NEED_W)
         else $error("time-out counter too narrow for the largest frame");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic             running;
   logic             restart;
   logic             at_end;

   assign limit   = CNT_W'({char_bits, 2'b00}) + CNT_W'(12);
   assign running = (rx_level != '0);
   assign restart = !running || rx_char || rhr_rd;
   assign at_end  = (cnt == limit);
   assign fire    = !restart && bit_tick && (cnt == limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (restart)           cnt <= '0;
      else if (bit_tick && !at_end) cnt <= cnt + CNT_W'(1);
   end

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> (cnt == '0) || (rx_level != '0) || $past(rx_level != '0));

   assert_fire_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> running);

endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
   import uart_irq_pkg::*;
(
   input  logic [NUM_LVL-1:0] lvl,
   output irq_code_e          code
);

   always_comb begin
      code = IC_NONE;
      for (int i = NUM_LVL - 1; i >= 0; i--) begin
         if (lvl[i]) code = lvl_code(i);
      end
   end

   always_comb begin
      assert_code_R3: assert ((code == IC_NONE) == (lvl == '0));
   end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int LVL_W    = 7,
   parameter int CHAR_W   = 4,
   parameter int CNT_W    = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic [5:0]        src_en,
   input  logic [3:0]        line_err,
   input  logic              lsr_rd,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [LVL_W-1:0]  rx_trig,
   input  logic              rx_char,
   input  logic              rhr_rd,
   input  logic              bit_tick,
   input  logic [CHAR_W-1:0] char_bits,
   input  logic              tx_trig_hit,
   input  logic              tx_empty,
   input  logic              thr_wr,
   input  logic              isr_rd,
   input  logic [3:0]        msr_delta,
   input  logic              msr_rd,
   input  logic              xon_det,
   input  logic              xoff_det,
   input  logic              spec_det,
   input  logic [1:0]        flow_pin,
   input  logic [1:0]        flow_auto,
   input  logic              wake_evt,
   input  logic              gir_rd,
   output logic [7:0]        isr_byte,
   output logic              irq,
   output logic              wake_flag
);

   localparam int NUM_PIN = 2;

   initial begin
      assert_lvl_width_R5: assert (LVL_W >= 1 && LVL_W <= 16)
         else $error("LVL_W out of range");
   end

   logic [NUM_LATCH-1:0] set_v, clr_v, pend;
   logic [NUM_PIN-1:0]   pin_q, pin_rise;
   logic                 to_fire;
   logic                 rx_ready;
   logic [NUM_LVL-1:0]   lvl;
   irq_code_e            code;

   // pin edge detectors, one per flow pin pair
   generate
      for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q[p] <= 1'b0;
            else        pin_q[p] <= flow_pin[p];
         end
         assign pin_rise[p] = flow_pin[p] && !pin_q[p] && flow_auto[p];
      end
   endgenerate

   uart_irq_timeout #(
      .LVL_W  (LVL_W),
      .CHAR_W (CHAR_W),
      .CNT_W  (CNT_W)
   ) u_timeout (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_level  (rx_level),
      .rx_char   (rx_char),
      .rhr_rd    (rhr_rd),
      .bit_tick  (bit_tick),
      .char_bits (char_bits),
      .fire      (to_fire)
   );

   // set and clear conditions of each latch
   always_comb begin
      set_v = '0;
      clr_v = '0;
      set_v[LT_LINE]  = |line_err;
      clr_v[LT_LINE]  = lsr_rd;
      set_v[LT_RXTO]  = to_fire;
      clr_v[LT_RXTO]  = rhr_rd;
      set_v[LT_TX]    = tx_trig_hit || tx_empty;
      clr_v[LT_TX]    = thr_wr || (isr_rd && code == IC_TXRDY);
      set_v[LT_MODEM] = |msr_delta;
      clr_v[LT_MODEM] = msr_rd;
      set_v[LT_FLOWC] = xon_det || xoff_det;
      clr_v[LT_FLOWC] = isr_rd;
      set_v[LT_SPEC]  = spec_det;
      clr_v[LT_SPEC]  = isr_rd || rx_char;
      set_v[LT_PIN0]  = pin_rise[0];
      clr_v[LT_PIN0]  = msr_rd;
      set_v[LT_PIN1]  = pin_rise[1];
      clr_v[LT_PIN1]  = msr_rd;
      set_v[LT_WAKE]  = wake_evt;
      clr_v[LT_WAKE]  = gir_rd;
   end

   generate
      for (genvar k = 0; k < NUM_LATCH; k++) begin : g_src
         uart_irq_latch #(.SET_WINS(SET_WINS)) u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_v[k]),
            .clr   (clr_v[k]),
            .pend  (pend[k])
         );
      end
   endgenerate

   assign rx_ready = (rx_level != '0) && (rx_level >= rx_trig);

   always_comb begin
      lvl[0] = pend[LT_LINE]  && src_en[0];
      lvl[1] = rx_ready       && src_en[1];
      lvl[2] = pend[LT_RXTO]  && src_en[1];
      lvl[3] = pend[LT_TX]    && src_en[2];
      lvl[4] = pend[LT_MODEM] && src_en[3];
      lvl[5] = (pend[LT_FLOWC] || pend[LT_SPEC]) && src_en[4];
      lvl[6] = (pend[LT_PIN0]  || pend[LT_PIN1]) && src_en[5];
   end

   uart_irq_encode u_encode (
      .lvl  (lvl),
      .code (code)
   );

   assign isr_byte  = {{2{fifo_en}}, code};
   assign wake_flag = pend[LT_WAKE];
   assign irq       = (|lvl) || wake_flag;

   assert_lsr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_rd && (line_err == 4'b0) |=> !pend[LT_LINE]);

   assert_tx_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty || tx_trig_hit) |=> pend[LT_TX]);

   assert_tx_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      isr_rd && (isr_byte[5:0] == IC_TXRDY) && !tx_empty && !tx_trig_hit |=> !pend[LT_TX]);

   assert_modem_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      msr_rd && (msr_delta == 4'b0) |=> !pend[LT_MODEM]);

   assert_spec_next_char_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_char && !spec_det |=> !pend[LT_SPEC]);

   assert_pin_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flow_auto[0] && flow_pin[0] && !pin_q[0] |=> pend[LT_PIN0]);

   assert_wake_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      gir_rd && !wake_evt |=> !wake_flag);

   assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_byte[5:0] == IC_NONE) && !wake_flag |-> !irq);

endmodule

// File: tb/uart_irq_prio_test.sv
`timescale 1ns/100ps
module uart_irq_prio_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b0;
   logic [5:0] src_en = 6'h3F;
   logic [3:0] line_err = '0;
   logic       lsr_rd = 0, rx_char = 0, rhr_rd = 0, bit_tick = 0;
   logic [6:0] rx_level = '0;
   logic [6:0] rx_trig = 7'd4;
   logic [3:0] char_bits = 4'd10;
   logic       tx_trig_hit = 0, tx_empty = 0, thr_wr = 0, isr_rd = 0;
   logic [3:0] msr_delta = '0;
   logic       msr_rd = 0, xon_det = 0, xoff_det = 0, spec_det = 0;
   logic [1:0] flow_pin = '0;
   logic [1:0] flow_auto = 2'b11;
   logic       wake_evt = 0, gir_rd = 0;
   logic [7:0] isr_byte;
   logic       irq, wake_flag;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   uart_irq_prio uut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .src_en(src_en),
      .line_err(line_err), .lsr_rd(lsr_rd), .rx_level(rx_level), .rx_trig(rx_trig),
      .rx_char(rx_char), .rhr_rd(rhr_rd), .bit_tick(bit_tick), .char_bits(char_bits),
      .tx_trig_hit(tx_trig_hit), .tx_empty(tx_empty), .thr_wr(thr_wr), .isr_rd(isr_rd),
      .msr_delta(msr_delta), .msr_rd(msr_rd), .xon_det(xon_det), .xoff_det(xoff_det),
      .spec_det(spec_det), .flow_pin(flow_pin), .flow_auto(flow_auto),
      .wake_evt(wake_evt), .gir_rd(gir_rd), .isr_byte(isr_byte), .irq(irq),
      .wake_flag(wake_flag)
   );

   // vector: {op[3:0], arg[6:0], expected status[7:0], expected irq, requirement number[3:0]}
   localparam int NV = 25;
   localparam logic [23:0] VEC [NV] = '{
      {4'd1,  7'd2, 8'hC6, 1'b1, 4'd4},   // R4 line error raises line status
      {4'd3,  7'd0, 8'hC6, 1'b1, 4'd3},   // R3 line outranks transmit
      {4'd2,  7'd0, 8'hC2, 1'b1, 4'd4},   // R4 line read clears
      {4'd6,  7'd1, 8'hC2, 1'b1, 4'd3},   // R3 transmit outranks modem
      {4'd4,  7'd0, 8'hC0, 1'b1, 4'd7},   // R7 status read returning tx clears it
      {4'd8,  7'd0, 8'hC0, 1'b1, 4'd3},   // R3 modem outranks character
      {4'd7,  7'd0, 8'hD0, 1'b1, 4'd8},   // R8 modem read clears
      {4'd4,  7'd0, 8'hC1, 1'b0, 4'd9},   // R9 status read clears flow char
      {4'd9,  7'd0, 8'hD0, 1'b1, 4'd9},   // R9 special char
      {4'd10, 7'd0, 8'hC1, 1'b0, 4'd9},   // R9 next char clears special
      {4'd12, 7'd5, 8'hC4, 1'b1, 4'd5},   // R5 level above trigger
      {4'd12, 7'd3, 8'hC1, 1'b0, 4'd5},   // R5 level below trigger
      {4'd11, 7'd1, 8'hE0, 1'b1, 4'd10},  // R10 input pin rise
      {4'd7,  7'd0, 8'hC1, 1'b0, 4'd10},  // R10 modem read clears pin change
      {4'd3,  7'd0, 8'hC2, 1'b1, 4'd7},
      {4'd4,  7'd0, 8'hC1, 1'b0, 4'd7},
      {4'd14, 7'd0, 8'hC2, 1'b1, 4'd7},   // R7 trigger hit raises tx
      {4'd5,  7'd0, 8'hC1, 1'b0, 4'd7},   // R7 holding write clears
      {4'd1,  7'd8, 8'hC6, 1'b1, 4'd4},
      {4'd3,  7'd0, 8'hC6, 1'b1, 4'd7},
      {4'd4,  7'd0, 8'hC6, 1'b1, 4'd7},   // R7 read returned line: tx kept
      {4'd2,  7'd0, 8'hC2, 1'b1, 4'd7},
      {4'd5,  7'd0, 8'hC1, 1'b0, 4'd7},
      {4'd12, 7'd0, 8'hC1, 1'b0, 4'd5},
      {4'd11, 7'd0, 8'hC1, 1'b0, 4'd10}
   };

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic chk(input string req, input logic [7:0] exp_isr, input logic exp_irq);
      n_chk++;
      if (isr_byte !== exp_isr || irq !== exp_irq) begin
         n_bad++;
         $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                  req, isr_byte, irq, exp_isr, exp_irq);
      end
   endtask

   task automatic chk_wake(input string req, input logic exp_w);
      n_chk++;
      if (wake_flag !== exp_w) begin
         n_bad++;
         $display("FAIL %s: wake_flag=%b expected %b", req, wake_flag, exp_w);
      end
   endtask

   // one clock with current inputs, then sample and drop strobes
   task automatic step();
      @(posedge clk);
      #1;
      line_err = '0; lsr_rd = 0; rx_char = 0; rhr_rd = 0; bit_tick = 0;
      tx_trig_hit = 0; tx_empty = 0; thr_wr = 0; isr_rd = 0; msr_delta = '0;
      msr_rd = 0; xon_det = 0; xoff_det = 0; spec_det = 0; wake_evt = 0; gir_rd = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1'b1;
         step();
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [6:0] arg);
      case (op)
         4'd1:  line_err = arg[3:0];
         4'd2:  lsr_rd = 1'b1;
         4'd3:  tx_empty = 1'b1;
         4'd4:  isr_rd = 1'b1;
         4'd5:  thr_wr = 1'b1;
         4'd6:  msr_delta = arg[3:0];
         4'd7:  msr_rd = 1'b1;
         4'd8:  xon_det = 1'b1;
         4'd9:  spec_det = 1'b1;
         4'd10: rx_char = 1'b1;
         4'd11: flow_pin = arg[1:0];
         4'd12: rx_level = arg;
         4'd13: rhr_rd = 1'b1;
         4'd14: tx_trig_hit = 1'b1;
         default: ;
      endcase
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state, FIFOs disabled
      chk("R1 reset status", 8'h01, 1'b0);
      chk_wake("R1 reset wake", 1'b0);
      rst_n = 1'b1;
      step();
      fifo_en = 1'b1;
      step();
      chk("R2 fifo bits set", 8'hC1, 1'b0);

      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][23:20], VEC[v][19:13]);
         chk($sformatf("R%0d vector %0d", VEC[v][3:0], v), VEC[v][12:5], VEC[v][4]);
      end

      // R2 FIFO-enable bits follow fifo_en
      fifo_en = 1'b0;
      apply(4'd1, 7'd1);
      chk("R2 fifo off with line", 8'h06, 1'b1);
      apply(4'd2, 7'd0);
      chk("R2 fifo off idle", 8'h01, 1'b0);
      fifo_en = 1'b1;

      // R3 / R12 masking by src_en
      src_en = 6'b111110;
      apply(4'd1, 7'd4);
      chk("R12 masked line, no irq", 8'hC1, 1'b0);
      src_en = 6'h3F;
      step();
      chk("R3 unmasked line shows", 8'hC6, 1'b1);
      apply(4'd2, 7'd0);
      chk("R3 cleared", 8'hC1, 1'b0);

      // R6 time-out: 4*10+12 = 52 ticks
      rx_level = 7'd3;
      apply(4'd10, 7'd0);
      ticks(51);
      chk("R6 one tick before limit", 8'hC1, 1'b0);
      ticks(1);
      chk("R6 time-out at limit", 8'hCC, 1'b1);
      apply(4'd13, 7'd0);
      chk("R6 holding read clears", 8'hC1, 1'b0);
      ticks(30);
      apply(4'd10, 7'd0);
      ticks(51);
      chk("R6 restart on char", 8'hC1, 1'b0);
      ticks(1);
      chk("R6 time-out after restart", 8'hCC, 1'b1);
      apply(4'd13, 7'd0);
      rx_level = 7'd0;
      ticks(60);
      chk("R6 empty FIFO holds timer", 8'hC1, 1'b0);

      // R13 set and clear in the same cycle
      apply(4'd3, 7'd0);
      chk("R13 tx raised", 8'hC2, 1'b1);
      isr_rd = 1'b1;
      tx_empty = 1'b1;
      step();
      chk("R13 tx kept on read plus event", 8'hC2, 1'b1);
      apply(4'd5, 7'd0);
      chk("R13 tx cleared by write", 8'hC1, 1'b0);
      spec_det = 1'b1;
      rx_char = 1'b1;
      step();
      chk("R13 special kept with char", 8'hD0, 1'b1);
      apply(4'd4, 7'd0);
      chk("R9 special cleared by status read", 8'hC1, 1'b0);

      // R10 pin change ignored without automatic flow control
      flow_auto = 2'b00;
      apply(4'd11, 7'd1);
      chk("R10 rise ignored when disabled", 8'hC1, 1'b0);
      apply(4'd11, 7'd0);
      flow_auto = 2'b11;
      apply(4'd11, 7'd2);
      chk("R10 output pin rise", 8'hE0, 1'b1);
      apply(4'd7, 7'd0);
      chk("R10 cleared", 8'hC1, 1'b0);
      apply(4'd11, 7'd0);

      // R11 wake flag, not masked by enables
      src_en = 6'h00;
      wake_evt = 1'b1;
      step();
      chk_wake("R11 wake set", 1'b1);
      chk("R11 wake drives irq", 8'hC1, 1'b1);
      gir_rd = 1'b1;
      step();
      chk_wake("R11 wake cleared", 1'b0);
      chk("R12 irq low", 8'hC1, 1'b0);
      src_en = 6'h3F;

      summary();
   end

endmodule